// File: doc/BRIEF.md
# Processor Exception Entry Unit

This unit decides what a MIPS-style core does when it takes an exception. On each entry request it receives an exception code, a branch-delay flag and the faulting program counter. From these and the Status register it keeps, it computes the new program counter, the Cause register, the exception return address (EPC) and the updated exception-level bit. The unit sorts codes into classes and supports two error levels. Each error level has its own vector table. The vector base is chosen by a bootstrap bit in Status, and which bit is used depends on the error level.

A pending-interrupt input lets the unit start an interrupt entry by itself. It does so only when Status allows it: the line's mask bit, the interrupt-enable bits, and both exception-level bits clear. A Status load port lets the core restore or change Status, for example on return from a handler. Every register the unit owns is loaded with a fixed value at reset. Each entry is followed one cycle later by a single-cycle completion pulse, and the results appear on registered outputs.

Top module: `exc_entry_unit`

## Requirements
- R1: After reset, pc_o is 0xBFC00000, config_o is 0x00000440, status_o is 0x70400004, prid_o is 0x00002E20, and cause_o, epc_o, done_o and err_o are zero.
- R2: When Status bit 2 (error level) is 0, the vector offset depends on code bits [6:2]. A value of 2 or 3 (codes 0x8 and 0xC) gives offset 0x000. A value of 0 gives offset 0x200. Any other value gives offset 0x180.
- R3: When Status bit 2 is 1 and code bits [17:15] are 0 or 1, pc_o becomes 0xBFC00000. EPC and Status keep their values, and Cause becomes code[15:0] with bit 31 clear.
- R4: When Status bit 2 is 1, a value of 2 in code bits [17:15] gives offset 0x080, and a value of 3 gives offset 0x100.
- R5: Every entry writes code[15:0] into Cause bits [15:0] and clears Cause bits [30:16].
- R6: If Status bit 1 (EXL) is 0 at entry, EXL is set. With the branch-delay flag set, EPC becomes req_pc−4 and Cause bit 31 is set. With the flag clear, EPC becomes req_pc and Cause bit 31 is cleared.
- R7: If EXL is already 1 at entry, EPC is unchanged, Cause bit 31 is clear and the offset is forced to 0x180 for every class except the one in R3.
- R8: The new PC is 0x80000000 plus the offset when the governing bit is 0, and 0xBFC00200 plus the offset when it is 1. The governing bit is Status bit 22 when Status bit 2 is 0, and Status bit 23 when Status bit 2 is 1.
- R9: With no request, pending line i starts an interrupt entry with code 0 only when Status bit 10+i, bit 16 and bit 0 are all 1 and bits 1 and 2 are 0.
- R10: At error level 2, a code with bits [17:15] from 4 to 7 sets err_o and uses offset 0x000. Any other entry clears err_o.
- R11: done_o is high for exactly the cycle after each entry and low otherwise. stat_wr loads Status when no entry starts in that cycle, and is ignored when an entry starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Exception entry request |
| req_code | input | 18 | Exception code |
| req_bd | input | 1 | Faulting instruction sits in a branch-delay slot |
| req_pc | input | 32 | Current program counter |
| irq_pend | input | IRQ_W | Pending interrupt lines |
| stat_wr | input | 1 | Load Status from stat_wdata |
| stat_wdata | input | 32 | New Status value |
| pc_o | output | 32 | Program counter after entry |
| cause_o | output | 32 | Cause register |
| epc_o | output | 32 | Exception return address |
| status_o | output | 32 | Status register |
| config_o | output | 32 | Configuration register |
| prid_o | output | 32 | Processor identification register |
| done_o | output | 1 | Entry completed in the previous cycle |
| err_o | output | 1 | Last entry had an unknown level-2 class |

## Verification
The main sweep sets every combination of error level, EXL, BEV and DEV. For each one it applies twelve codes with the branch-delay flag both clear and set. The codes cover refill, interrupt and general classes at level 0–1, and reset, performance, debug and unknown classes at level 2. Some codes carry stray high bits, which show that each level decodes only its own field. Running each case with EXL at 0 and at 1 separates the written EPC from the held EPC and the class offset from the forced general offset. Flipping BEV and DEV at both levels shows which of them governs the base. Interrupt cases change one enable condition at a time and hold the line pending after entry. A Status load in the same cycle as an entry checks that the entry wins.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int CODE_W  = 18;
  localparam int ST_IE   = 0;
  localparam int ST_EXL  = 1;
  localparam int ST_ERL  = 2;
  localparam int ST_EIE  = 16;
  localparam int ST_BEV  = 22;
  localparam int ST_DEV  = 23;

  typedef enum logic [2:0] {
    CLS_REFILL  = 3'd0,
    CLS_INTR    = 3'd1,
    CLS_GENERAL = 3'd2,
    CLS_RESET   = 3'd3,
    CLS_PERF    = 3'd4,
    CLS_DEBUG   = 3'd5,
    CLS_UNKNOWN = 3'd6
  } exc_cls_e;

  // kind = code[6:2] (level 0-1 field), lvl2_fld = code[17:15] (level 2 field)
  function automatic exc_cls_e classify_code(input logic [4:0] kind,
                                             input logic [2:0] lvl2_fld,
                                             input logic       erl);
    exc_cls_e c;
    if (!erl) begin
      if (kind == 5'd2 || kind == 5'd3) c = CLS_REFILL;
      else if (kind == 5'd0)            c = CLS_INTR;
      else                              c = CLS_GENERAL;
    end else begin
      case (lvl2_fld)
        3'd0, 3'd1: c = CLS_RESET;
        3'd2:       c = CLS_PERF;
        3'd3:       c = CLS_DEBUG;
        default:    c = CLS_UNKNOWN;
      endcase
    end
    return c;
  endfunction

  function automatic logic [9:0] class_offset(input exc_cls_e c, input logic exl);
    logic [9:0] off;
    if (exl) off = 10'h180;
    else begin
      case (c)
        CLS_INTR:    off = 10'h200;
        CLS_GENERAL: off = 10'h180;
        CLS_PERF:    off = 10'h080;
        CLS_DEBUG:   off = 10'h100;
        default:     off = 10'h000;
      endcase
    end
    return off;
  endfunction

  function automatic logic [31:0] return_addr(input logic [31:0] pc, input logic bd);
    return bd ? (pc - 32'd4) : pc;
  endfunction

endpackage

// File: rtl/exc_class_sel.sv
module exc_class_sel
  import exc_entry_pkg::*;
(
  input  logic [4:0] kind,
  input  logic [2:0] lvl2_fld,
  input  logic       erl,
  input  logic       exl,
  input  logic       bev,
  input  logic       dev,
  output exc_cls_e   cls,
  output logic [9:0] offset,
  output logic       gov_bit,
  output logic       reset_cls,
  output logic       unknown_cls
);
  always_comb begin
    cls         = classify_code(kind, lvl2_fld, erl);
    offset      = class_offset(cls, exl);
    gov_bit     = erl ? dev : bev;
    reset_cls   = (cls == CLS_RESET);
    unknown_cls = (cls == CLS_UNKNOWN);
  end
endmodule

// File: rtl/exc_irq_gate.sv
module exc_irq_gate #(
  parameter int IRQ_W = 2
) (
  input  logic [IRQ_W-1:0] pend,
  input  logic [IRQ_W-1:0] mask,
  input  logic             ie,
  input  logic             eie,
  input  logic             exl,
  input  logic             erl,
  output logic             irq_ok
);
  logic [IRQ_W-1:0] line_hit;

  for (genvar g = 0; g < IRQ_W; g++) begin : g_line
    assign line_hit[g] = pend[g] & mask[g];
  end

  assign irq_ok = (|line_hit) & ie & eie & ~exl & ~erl;
endmodule

// File: rtl/exc_entry_calc.sv
module exc_entry_calc
  import exc_entry_pkg::*;
#(
  parameter logic [31:0] GEN_BASE  = 32'h8000_0000,
  parameter logic [31:0] BOOT_BASE = 32'hBFC0_0200,
  parameter logic [31:0] RESET_PC  = 32'hBFC0_0000
) (
  input  logic [31:0] pc,
  input  logic        bd,
  input  logic [15:0] cause_lo,
  input  logic        exl_in,
  input  logic        reset_cls,
  input  logic        gov_bit,
  input  logic [9:0]  offset,
  output logic [31:0] vec_pc,
  output logic [31:0] cause_nxt,
  output logic        epc_we,
  output logic [31:0] epc_nxt,
  output logic        exl_nxt
);
  localparam logic [31:0] OFF_PAD = 32'd0;

  always_comb begin
    cause_nxt = {16'h0000, cause_lo};
    epc_nxt   = return_addr(pc, bd);
    epc_we    = 1'b0;
    exl_nxt   = exl_in;
    if (reset_cls) begin
      vec_pc = RESET_PC;
    end else begin
      vec_pc = (gov_bit ? BOOT_BASE : GEN_BASE) + (OFF_PAD | {22'd0, offset});
      exl_nxt = 1'b1;
      if (!exl_in) begin
        epc_we        = 1'b1;
        cause_nxt[31] = bd;
      end
    end
  end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_entry_pkg::*;
#(
  parameter int          IRQ_W       = 2,
  parameter int          IRQ_LSB     = 10,
  parameter logic [31:0] GEN_BASE    = 32'h8000_0000,
  parameter logic [31:0] BOOT_BASE   = 32'hBFC0_0200,
  parameter logic [31:0] RESET_PC    = 32'hBFC0_0000,
  parameter logic [31:0] INIT_STATUS = 32'h7040_0004,
  parameter logic [31:0] INIT_CONFIG = 32'h0000_0440,
  parameter logic [31:0] INIT_PRID   = 32'h0000_2E20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [CODE_W-1:0] req_code,
  input  logic              req_bd,
  input  logic [31:0]       req_pc,
  input  logic [IRQ_W-1:0]  irq_pend,
  input  logic              stat_wr,
  input  logic [31:0]       stat_wdata,
  output logic [31:0]       pc_o,
  output logic [31:0]       cause_o,
  output logic [31:0]       epc_o,
  output logic [31:0]       status_o,
  output logic [31:0]       config_o,
  output logic [31:0]       prid_o,
  output logic              done_o,
  output logic              err_o
);
  logic [31:0] pc_q, cause_q, epc_q, status_q, config_q, prid_q;
  logic        done_q, err_q;

  // named internal events, also observed by the checker
  logic              irq_ok, irq_go, go, lvl2_sel;
  logic [CODE_W-1:0] eff_code;
  exc_cls_e          cls;
  logic [9:0]        offset;
  logic              gov_bit, reset_cls, unknown_cls;
  logic [31:0]       vec_pc, cause_nxt, epc_nxt;
  logic              epc_we, exl_nxt;

  exc_irq_gate #(.IRQ_W(IRQ_W)) u_irq (
    .pend   (irq_pend),
    .mask   (status_q[IRQ_LSB +: IRQ_W]),
    .ie     (status_q[ST_IE]),
    .eie    (status_q[ST_EIE]),
    .exl    (status_q[ST_EXL]),
    .erl    (status_q[ST_ERL]),
    .irq_ok (irq_ok)
  );

  assign irq_go   = irq_ok & ~req_valid;
  assign go       = req_valid | irq_go;
  assign eff_code = req_valid ? req_code : '0;
  assign lvl2_sel = status_q[ST_ERL];

  exc_class_sel u_cls (
    .kind        (eff_code[6:2]),
    .lvl2_fld    (eff_code[17:15]),
    .erl         (status_q[ST_ERL]),
    .exl         (status_q[ST_EXL]),
    .bev         (status_q[ST_BEV]),
    .dev         (status_q[ST_DEV]),
    .cls         (cls),
    .offset      (offset),
    .gov_bit     (gov_bit),
    .reset_cls   (reset_cls),
    .unknown_cls (unknown_cls)
  );

  exc_entry_calc #(
    .GEN_BASE  (GEN_BASE),
    .BOOT_BASE (BOOT_BASE),
    .RESET_PC  (RESET_PC)
  ) u_calc (
    .pc        (req_pc),
    .bd        (req_bd),
    .cause_lo  (eff_code[15:0]),
    .exl_in    (status_q[ST_EXL]),
    .reset_cls (reset_cls),
    .gov_bit   (gov_bit),
    .offset    (offset),
    .vec_pc    (vec_pc),
    .cause_nxt (cause_nxt),
    .epc_we    (epc_we),
    .epc_nxt   (epc_nxt),
    .exl_nxt   (exl_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q     <= RESET_PC;
      cause_q  <= '0;
      epc_q    <= '0;
      status_q <= INIT_STATUS;
      config_q <= INIT_CONFIG;
      prid_q   <= INIT_PRID;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= go;
      if (go) begin
        pc_q             <= vec_pc;
        cause_q          <= cause_nxt;
        status_q[ST_EXL] <= exl_nxt;
        err_q            <= unknown_cls;
        if (epc_we) epc_q <= epc_nxt;
      end else if (stat_wr) begin
        status_q <= stat_wdata;
      end
    end
  end

  assign pc_o     = pc_q;
  assign cause_o  = cause_q;
  assign epc_o    = epc_q;
  assign status_o = status_q;
  assign config_o = config_q;
  assign prid_o   = prid_q;
  assign done_o   = done_q;
  assign err_o    = err_q;
endmodule

// File: rtl/exc_entry_unit_chk.sv
module exc_entry_unit_chk #(
  parameter logic [31:0] GEN_BASE  = 32'h8000_0000,
  parameter logic [31:0] BOOT_BASE = 32'hBFC0_0200,
  parameter logic [31:0] RESET_PC  = 32'hBFC0_0000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        go,
  input logic        irq_go,
  input logic        reset_cls,
  input logic        lvl2_sel,
  input logic [31:0] pc_o,
  input logic [31:0] epc_o,
  input logic [31:0] status_o,
  input logic        done_o,
  input logic        err_o
);
  AST_DONE_AFTER_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> done_o); // R11
  AST_NO_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> !done_o); // R11
  AST_RESET_CLASS_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    go && reset_cls |=> (pc_o == RESET_PC) && $stable(status_o) && $stable(epc_o)); // R3
  AST_EXL_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    go && !reset_cls |=> status_o[1]); // R6
  AST_EPC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    go && status_o[1] |=> $stable(epc_o)); // R7
  AST_IRQ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[1] || status_o[2]) |-> !irq_go); // R9
  AST_NO_ERR_LOW_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    go && !lvl2_sel |=> !err_o); // R10
  AST_PC_IN_VECTOR_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (pc_o[31:12] == GEN_BASE[31:12]) || (pc_o[31:12] == BOOT_BASE[31:12])
               || (pc_o == RESET_PC)); // R8
endmodule

bind exc_entry_unit exc_entry_unit_chk #(
  .GEN_BASE  (GEN_BASE),
  .BOOT_BASE (BOOT_BASE),
  .RESET_PC  (RESET_PC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .go        (go),
  .irq_go    (irq_go),
  .reset_cls (reset_cls),
  .lvl2_sel  (lvl2_sel),
  .pc_o      (pc_o),
  .epc_o     (epc_o),
  .status_o  (status_o),
  .done_o    (done_o),
  .err_o     (err_o)
);

// File: tb/exc_entry_unit_tb_top.sv
`timescale 1ns/1ps
module exc_entry_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [17:0] req_code = '0;
  logic        req_bd = 1'b0;
  logic [31:0] req_pc = '0;
  logic [1:0]  irq_pend = '0;
  logic        stat_wr = 1'b0;
  logic [31:0] stat_wdata = '0;
  logic [31:0] pc_o, cause_o, epc_o, status_o, config_o, prid_o;
  logic        done_o, err_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [31:0] m_pc, m_cause, m_epc, m_status;
  logic        m_err;

  always #4 clk = ~clk;

  exc_entry_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
    .req_bd(req_bd), .req_pc(req_pc), .irq_pend(irq_pend), .stat_wr(stat_wr),
    .stat_wdata(stat_wdata), .pc_o(pc_o), .cause_o(cause_o), .epc_o(epc_o),
    .status_o(status_o), .config_o(config_o), .prid_o(prid_o),
    .done_o(done_o), .err_o(err_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Independent model of one entry, updating m_* from the requirement text
  task automatic model_entry(input logic [17:0] code, input logic bd, input logic [31:0] pc);
    int unsigned lvl2_val, kind_val, off, base;
    logic erl, exl, gov;
    erl = m_status[2];
    exl = m_status[1];
    lvl2_val = int'(code) & 32'h38000;
    kind_val = int'(code) & 32'h7C;
    m_cause = {16'h0, code[15:0]};                     // R5
    m_err = 1'b0;
    if (erl && lvl2_val <= 32'h8000) begin             // R3
      m_pc = 32'hBFC0_0000;
      return;
    end
    if (!erl) begin                                    // R2
      if (kind_val == 8 || kind_val == 12) off = 0;
      else if (kind_val == 0)              off = 32'h200;
      else                                 off = 32'h180;
      gov = m_status[22];
    end else begin                                     // R4 / R10
      if (lvl2_val == 32'h10000)      off = 32'h80;
      else if (lvl2_val == 32'h18000) off = 32'h100;
      else begin off = 0; m_err = 1'b1; end
      gov = m_status[23];
    end
    if (exl) off = 32'h180;                            // R7
    else begin                                         // R6
      m_epc = bd ? pc - 32'd4 : pc;
      m_cause[31] = bd;
    end
    base = gov ? 32'hBFC0_0200 : 32'h8000_0000;        // R8
    m_pc = base + off;
    m_status[1] = 1'b1;
  endtask

  task automatic load_status(input logic [31:0] s);
    @(negedge clk);
    stat_wr = 1'b1; stat_wdata = s;
    @(negedge clk);
    stat_wr = 1'b0;
    m_status = s;
  endtask

  task automatic compare_all(input string tag);
    chk({tag, " pc"}, pc_o, m_pc);
    chk({tag, " cause"}, cause_o, m_cause);
    chk({tag, " epc"}, epc_o, m_epc);
    chk({tag, " status"}, status_o, m_status);
    chk({tag, " err"}, {31'd0, err_o}, {31'd0, m_err});
  endtask

  initial begin
    logic [17:0] codes [12];
    codes = '{18'h00000, 18'h00004, 18'h00008, 18'h0000C, 18'h00010, 18'h0007C,
              18'h00083, 18'h08008, 18'h10000, 18'h18024, 18'h20000, 18'h3FFFF};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 pc", pc_o, 32'hBFC0_0000);
    chk("R1 config", config_o, 32'h0000_0440);
    chk("R1 status", status_o, 32'h7040_0004);
    chk("R1 prid", prid_o, 32'h0000_2E20);
    chk("R1 cause", cause_o, 32'h0);
    chk("R1 epc", epc_o, 32'h0);
    chk("R1 done", {31'd0, done_o}, 32'h0);
    chk("R1 err", {31'd0, err_o}, 32'h0);
    m_pc = 32'hBFC0_0000; m_cause = 0; m_epc = 0; m_status = 32'h7040_0004; m_err = 0;

    // Sweep R2..R8, R10
    for (int st = 0; st < 16; st++) begin
      for (int ci = 0; ci < 12; ci++) begin
        for (int b = 0; b < 2; b++) begin
          logic [31:0] s;
          logic [31:0] pcv;
          s = 32'h1000_0000;
          s[2]  = st[0];
          s[1]  = st[1];
          s[22] = st[2];
          s[23] = st[3];
          pcv = 32'h0010_0000 + 32'(st * 4096 + ci * 64 + b * 8);
          load_status(s);
          req_valid = 1'b1; req_code = codes[ci]; req_bd = b[0]; req_pc = pcv;
          model_entry(codes[ci], b[0], pcv);
          @(negedge clk);
          req_valid = 1'b0;
          compare_all("R2-sweep R3 R4 R5 R6 R7 R8 R10");
          chk("R11 done pulse", {31'd0, done_o}, 32'h1);
          @(negedge clk);
          chk("R11 done low", {31'd0, done_o}, 32'h0);
        end
      end
    end

    // R9: interrupt accepted on line 0
    req_pc = 32'h0000_4444; req_bd = 1'b0;
    load_status(32'h0001_0401);
    irq_pend = 2'b01;
    model_entry(18'h0, 1'b0, 32'h0000_4444);
    @(negedge clk);
    compare_all("R9 irq0");
    chk("R9 irq0 done", {31'd0, done_o}, 32'h1);
    @(negedge clk);
    chk("R9 blocked by EXL done", {31'd0, done_o}, 32'h0);
    chk("R9 blocked by EXL pc", pc_o, m_pc);
    irq_pend = 2'b00;

    // R9: line 1 with its own mask bit, branch delay
    req_bd = 1'b1; req_pc = 32'h0000_8888;
    load_status(32'h0001_0801);
    irq_pend = 2'b10;
    model_entry(18'h0, 1'b1, 32'h0000_8888);
    @(negedge clk);
    compare_all("R9 irq1");
    irq_pend = 2'b00; req_bd = 1'b0;

    // R9: one enable missing at a time -> no entry
    for (int k = 0; k < 4; k++) begin
      logic [31:0] s;
      s = 32'h0001_0401;
      case (k)
        0: s[16] = 1'b0;
        1: s[0]  = 1'b0;
        2: s[2]  = 1'b1;
        default: s = 32'h0001_0801;
      endcase
      load_status(s);
      irq_pend = 2'b01;
      @(negedge clk);
      chk("R9 no entry done", {31'd0, done_o}, 32'h0);
      chk("R9 no entry status", status_o, s);
      chk("R9 no entry pc", pc_o, m_pc);
      irq_pend = 2'b00;
    end

    // R11: Status load ignored when an entry starts in the same cycle
    load_status(32'h0000_0000);
    @(negedge clk);
    stat_wr = 1'b1; stat_wdata = 32'hFFFF_FFFF;
    req_valid = 1'b1; req_code = 18'h00024; req_bd = 1'b0; req_pc = 32'h0000_1230;
    model_entry(18'h00024, 1'b0, 32'h0000_1230);
    @(negedge clk);
    stat_wr = 1'b0; req_valid = 1'b0;
    compare_all("R11 entry beats load");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #1600000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule